// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block resolves a translation-buffer miss in hardware. Given a 20-bit virtual page number, it follows a three-level table tree kept in ordinary memory. It starts at a root address held in a privileged base register. It makes one word read per level, and each entry it reads supplies the base of the next table. When the chain completes, the block returns the physical page number that the translation buffer should be refilled with. If any entry along the chain is marked invalid, it reports a page fault instead.

The memory side is a plain request/acknowledge/response port. The walker raises a read request with an address and holds both until the memory acknowledges. It then waits for a response strobe that carries the 32-bit entry. A caller starts a walk by pulsing a request while the walker is idle. The outcome comes back as a one-cycle pulse, either success or fault, together with the original page number and the resulting frame number.

Top module: `ptw_walker`

## Requirements
- R1: After reset the walker is idle (`walk_ready`=1), `mem_req`, `res_done` and `res_fault` are 0, and the root base register holds 0.
- R2: The first read address is the root base plus 4 × VPN bits [19:13], modulo 2^32.
- R3: The second read is at (first entry's PPN << 12) + 4 × VPN bits [12:6]. The third read is at (second entry's PPN << 12) + 4 × VPN bits [5:0].
- R4: An entry is valid when bit 31 is 1. Its PPN is bits [17:0]. Bits [30:18] have no effect on addresses or results.
- R5: A walk whose three entries are all valid makes exactly three reads. It then raises `res_done` for one cycle, with `res_vpn` equal to the requested VPN and `res_ppn` equal to the third entry's PPN.
- R6: When the entry read at any level is invalid, no further read is made. `res_fault` is raised for one cycle with `res_vpn` equal to the requested VPN and `res_ppn` equal to 0.
- R7: A write to the root base register takes effect only when `base_wr_kernel` is 1. A write with the flag at 0 leaves the register unchanged.
- R8: Once raised, `mem_req` and `mem_addr` stay unchanged until the cycle `mem_ack` is sampled high. Each level issues exactly one request.
- R9: A walk request is taken only while `walk_ready` is 1. A request raised during a walk has no effect on that walk or its result. No read is requested while idle.
- R10: Each accepted walk ends in exactly one of `res_done` or `res_fault`, and the two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_wr_en | input | 1 | Write strobe for the root base register |
| base_wr_kernel | input | 1 | Privilege flag of the writer; 1 = kernel |
| base_wr_data | input | 32 | New root table byte address |
| walk_req | input | 1 | Start a walk (taken only when idle) |
| walk_vpn | input | 20 | Virtual page number to translate |
| walk_ready | output | 1 | Walker idle and able to accept a walk |
| mem_req | output | 1 | Read request to memory |
| mem_addr | output | 32 | Byte address of the entry read |
| mem_ack | input | 1 | Memory accepted the request |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Table entry read |
| res_done | output | 1 | One-cycle pulse: translation found |
| res_fault | output | 1 | One-cycle pulse: page fault |
| res_vpn | output | 20 | Page number of the finished walk |
| res_ppn | output | 18 | Resulting physical page number (0 on fault) |

## Verification
The bench sweeps the fault level across none, first, second and third, and sweeps the acknowledge and response delays. A walker that kept reading after an invalid entry would show a fourth, second or third address in the read log. One that reported the faulted entry's PPN would return a nonzero frame. Entries carry junk in their ignored bits and nonzero PPNs even when invalid, so a decoder with the wrong field position shows up as a wrong next address. Root bases near the top of the address space, and all-ones and all-zero page numbers, probe the field split and the carry out of the first address sum. User-mode base writes and requests raised mid-walk must leave the read addresses and the echoed page number unchanged.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_L1_REQ,
    ST_L1_WAIT,
    ST_L2_REQ,
    ST_L2_WAIT,
    ST_L3_REQ,
    ST_L3_WAIT,
    ST_DONE,
    ST_FAULT
  } walk_state_e;

  typedef enum logic [1:0] {
    LVL_1 = 2'd0,
    LVL_2 = 2'd1,
    LVL_3 = 2'd2
  } walk_level_e;

endpackage

// File: rtl/ptw_base_reg.sv
module ptw_base_reg #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_kernel,
  input  logic [ADDR_W-1:0] wr_data,
  output logic [ADDR_W-1:0] base_q
);

  // Only a privileged writer may move the root of the table tree.
  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
    end else if (wr_en && wr_kernel) begin
      base_q <= wr_data;
    end
  end

endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
  import ptw_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int IDX1_W     = 7,
  parameter int IDX2_W     = 7,
  parameter int IDX3_W     = 6,
  parameter int ENTRY_LOG2 = 2
) (
  input  walk_level_e                         level,
  input  logic [ADDR_W-1:0]                   table_base,
  input  logic [IDX1_W+IDX2_W+IDX3_W-1:0]     vpn,
  output logic [ADDR_W-1:0]                   addr
);

  localparam int VPN_W = IDX1_W + IDX2_W + IDX3_W;

  logic [IDX1_W-1:0] idx1;
  logic [IDX2_W-1:0] idx2;
  logic [IDX3_W-1:0] idx3;
  logic [ADDR_W-1:0] offset;

  assign idx1 = vpn[VPN_W-1 -: IDX1_W];
  assign idx2 = vpn[IDX2_W+IDX3_W-1 -: IDX2_W];
  assign idx3 = vpn[IDX3_W-1:0];

  always_comb begin
    case (level)
      LVL_1:   offset = ADDR_W'(idx1) << ENTRY_LOG2;
      LVL_2:   offset = ADDR_W'(idx2) << ENTRY_LOG2;
      LVL_3:   offset = ADDR_W'(idx3) << ENTRY_LOG2;
      default: offset = '0;
    endcase
  end

  assign addr = table_base + offset;

endmodule

// File: rtl/ptw_pte_decode.sv
module ptw_pte_decode #(
  parameter int PTE_W      = 32,
  parameter int PPN_W      = 18,
  parameter int VALID_POS  = 31,
  parameter int PAGE_SHIFT = 12,
  parameter int ADDR_W     = 32
) (
  input  logic [PTE_W-1:0]  pte,
  output logic              valid,
  output logic [PPN_W-1:0]  ppn,
  output logic [ADDR_W-1:0] next_base
);

  assign valid     = pte[VALID_POS];
  assign ppn       = PPN_W'(pte);
  assign next_base = ADDR_W'(ppn) << PAGE_SHIFT;

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int PTE_W      = 32,
  parameter int IDX1_W     = 7,
  parameter int IDX2_W     = 7,
  parameter int IDX3_W     = 6,
  parameter int PPN_W      = 18,
  parameter int VALID_POS  = 31,
  parameter int PAGE_SHIFT = 12,
  parameter int ENTRY_LOG2 = 2
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             base_wr_en,
  input  logic                             base_wr_kernel,
  input  logic [ADDR_W-1:0]                base_wr_data,
  input  logic                             walk_req,
  input  logic [IDX1_W+IDX2_W+IDX3_W-1:0]  walk_vpn,
  output logic                             walk_ready,
  output logic                             mem_req,
  output logic [ADDR_W-1:0]                mem_addr,
  input  logic                             mem_ack,
  input  logic                             mem_rvalid,
  input  logic [PTE_W-1:0]                 mem_rdata,
  output logic                             res_done,
  output logic                             res_fault,
  output logic [IDX1_W+IDX2_W+IDX3_W-1:0]  res_vpn,
  output logic [PPN_W-1:0]                 res_ppn
);

  localparam int VPN_W = IDX1_W + IDX2_W + IDX3_W;

  walk_state_e       state_q;
  logic [VPN_W-1:0]  vpn_q;
  logic [ADDR_W-1:0] addr_q;
  logic [PPN_W-1:0]  ppn_q;

  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] gen_base;
  logic [VPN_W-1:0]  gen_vpn;
  walk_level_e       gen_level;
  logic [ADDR_W-1:0] gen_addr;

  logic              pte_valid;
  logic [PPN_W-1:0]  pte_ppn;
  logic [ADDR_W-1:0] pte_next_base;

  ptw_base_reg #(.ADDR_W(ADDR_W)) u_base (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (base_wr_en),
    .wr_kernel (base_wr_kernel),
    .wr_data   (base_wr_data),
    .base_q    (base_q)
  );

  ptw_pte_decode #(
    .PTE_W(PTE_W), .PPN_W(PPN_W), .VALID_POS(VALID_POS),
    .PAGE_SHIFT(PAGE_SHIFT), .ADDR_W(ADDR_W)
  ) u_pte (
    .pte       (mem_rdata),
    .valid     (pte_valid),
    .ppn       (pte_ppn),
    .next_base (pte_next_base)
  );

  // Address of the next read: from the root when starting, else from the entry just returned.
  always_comb begin
    if (state_q == ST_IDLE) begin
      gen_base  = base_q;
      gen_vpn   = walk_vpn;
      gen_level = LVL_1;
    end else begin
      gen_base  = pte_next_base;
      gen_vpn   = vpn_q;
      gen_level = (state_q == ST_L1_WAIT) ? LVL_2 : LVL_3;
    end
  end

  ptw_addr_gen #(
    .ADDR_W(ADDR_W), .IDX1_W(IDX1_W), .IDX2_W(IDX2_W),
    .IDX3_W(IDX3_W), .ENTRY_LOG2(ENTRY_LOG2)
  ) u_addr (
    .level      (gen_level),
    .table_base (gen_base),
    .vpn        (gen_vpn),
    .addr       (gen_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      vpn_q   <= '0;
      addr_q  <= '0;
      ppn_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (walk_req) begin
            vpn_q   <= walk_vpn;
            addr_q  <= gen_addr;
            state_q <= ST_L1_REQ;
          end
        end
        ST_L1_REQ: if (mem_ack) state_q <= ST_L1_WAIT;
        ST_L2_REQ: if (mem_ack) state_q <= ST_L2_WAIT;
        ST_L3_REQ: if (mem_ack) state_q <= ST_L3_WAIT;
        ST_L1_WAIT, ST_L2_WAIT: begin
          if (mem_rvalid) begin
            if (!pte_valid) begin
              ppn_q   <= '0;
              state_q <= ST_FAULT;
            end else begin
              addr_q  <= gen_addr;
              state_q <= (state_q == ST_L1_WAIT) ? ST_L2_REQ : ST_L3_REQ;
            end
          end
        end
        ST_L3_WAIT: begin
          if (mem_rvalid) begin
            if (!pte_valid) begin
              ppn_q   <= '0;
              state_q <= ST_FAULT;
            end else begin
              ppn_q   <= pte_ppn;
              state_q <= ST_DONE;
            end
          end
        end
        ST_DONE, ST_FAULT: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign walk_ready = (state_q == ST_IDLE);
  assign mem_req    = (state_q == ST_L1_REQ) || (state_q == ST_L2_REQ) ||
                      (state_q == ST_L3_REQ);
  assign mem_addr   = addr_q;
  assign res_done   = (state_q == ST_DONE);
  assign res_fault  = (state_q == ST_FAULT);
  assign res_vpn    = vpn_q;
  assign res_ppn    = ppn_q;

endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              walk_ready,
  input logic              mem_req,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              res_done,
  input logic              res_fault,
  input logic              base_wr_en,
  input logic              base_wr_kernel,
  input logic [ADDR_W-1:0] base_q
);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr))); // R8

  AST_DONE_FAULT_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(res_done && res_fault)); // R10

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    res_done |=> !res_done); // R5

  AST_FAULT_PULSE: assert property (@(posedge clk) disable iff (rst)
    res_fault |=> !res_fault); // R6

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    walk_ready |-> !mem_req); // R9

  AST_USER_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (base_wr_en && !base_wr_kernel) |=> $stable(base_q)); // R7

endmodule

bind ptw_walker ptw_walker_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .walk_ready     (walk_ready),
  .mem_req        (mem_req),
  .mem_ack        (mem_ack),
  .mem_addr       (mem_addr),
  .res_done       (res_done),
  .res_fault      (res_fault),
  .base_wr_en     (base_wr_en),
  .base_wr_kernel (base_wr_kernel),
  .base_q         (base_q)
);

// File: tb/tb_ptw_walker.sv
module tb_ptw_walker;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        base_wr_en, base_wr_kernel;
  logic [31:0] base_wr_data;
  logic        walk_req;
  logic [19:0] walk_vpn;
  logic        walk_ready, mem_req, mem_ack, mem_rvalid;
  logic [31:0] mem_addr, mem_rdata;
  logic        res_done, res_fault;
  logic [19:0] res_vpn;
  logic [17:0] res_ppn;

  int checks = 0;
  int errors = 0;

  // Memory model state
  int          ack_lat = 0, rsp_lat = 0, fault_lvl = 0;
  int          ack_cnt = 0, rsp_cnt = 0, nreads = 0, rsp_lvl = 0;
  bit          rsp_pending = 0, hold_seen = 0;
  logic [31:0] rsp_addr, hold_addr;
  logic [31:0] rd_log [0:7];

  always #(CLK_PERIOD/2) clk = ~clk;

  ptw_walker dut (
    .clk(clk), .rst(rst),
    .base_wr_en(base_wr_en), .base_wr_kernel(base_wr_kernel), .base_wr_data(base_wr_data),
    .walk_req(walk_req), .walk_vpn(walk_vpn), .walk_ready(walk_ready),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .res_done(res_done), .res_fault(res_fault), .res_vpn(res_vpn), .res_ppn(res_ppn)
  );

  // Entry contents are an arithmetic function of address and level; junk in bits [30:18].
  function automatic logic [31:0] make_pte(logic [31:0] a, int lvl, bit ok);
    logic [17:0] p;
    logic [12:0] j;
    p = (a[19:2] ^ 18'h2A5C3) + 18'(lvl * 273);
    j = a[14:2] ^ 13'h0B7;
    return {ok, j, p};
  endfunction

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Memory responder, driven away from the active edge.
  initial begin
    mem_ack = 0; mem_rvalid = 0; mem_rdata = '0;
    forever begin
      @(negedge clk);
      mem_ack = 0; mem_rvalid = 0;
      if (rsp_pending) begin
        if (rsp_cnt == 0) begin
          mem_rvalid  = 1;
          mem_rdata   = make_pte(rsp_addr, rsp_lvl, fault_lvl != rsp_lvl);
          rsp_pending = 0;
        end else rsp_cnt--;
      end else if (mem_req) begin
        if (!hold_seen) begin hold_seen = 1; hold_addr = mem_addr; end
        if (ack_cnt == 0) begin
          mem_ack = 1;
          check(mem_addr == hold_addr, "R8", "address held until ack", mem_addr, hold_addr);
          hold_seen = 0;
          if (nreads < 8) rd_log[nreads] = mem_addr;
          nreads++;
          rsp_lvl = nreads;
          rsp_addr = mem_addr;
          rsp_pending = 1;
          rsp_cnt = rsp_lat;
          ack_cnt = ack_lat;
        end else ack_cnt--;
      end
    end
  end

  task automatic write_base(logic [31:0] v, bit kernel);
    @(negedge clk);
    base_wr_en = 1; base_wr_kernel = kernel; base_wr_data = v;
    @(negedge clk);
    base_wr_en = 0; base_wr_kernel = 0;
  endtask

  task automatic run_walk(logic [19:0] vpn, logic [31:0] root, int flvl,
                          int alat, int rlat, bit poke);
    logic [31:0] ea [0:2];
    logic [17:0] p1, p2, p3;
    int exp_reads, cyc;
    ea[0] = root + {25'd0, vpn[19:13], 2'b00};
    p1    = make_pte(ea[0], 1, 1'b1)[17:0];
    ea[1] = {14'd0, p1, 12'd0} + {25'd0, vpn[12:6], 2'b00};
    p2    = make_pte(ea[1], 2, 1'b1)[17:0];
    ea[2] = {14'd0, p2, 12'd0} + {26'd0, vpn[5:0], 2'b00};
    p3    = make_pte(ea[2], 3, 1'b1)[17:0];
    exp_reads = (flvl == 0) ? 3 : flvl;

    fault_lvl = flvl; ack_lat = alat; rsp_lat = rlat;
    ack_cnt = alat; nreads = 0; hold_seen = 0;
    @(negedge clk);
    walk_req = 1; walk_vpn = vpn;
    @(negedge clk);
    walk_req = 0;
    cyc = 0;
    while (!(res_done || res_fault) && cyc < 200) begin
      if (poke && cyc == 2) begin walk_req = 1; walk_vpn = ~vpn; end
      if (poke && cyc == 3) walk_req = 0;
      @(negedge clk);
      cyc++;
    end
    check(res_done == (flvl == 0), (flvl == 0) ? "R5" : "R6", "done flag", 32'(res_done), 32'(flvl == 0));
    check(res_fault == (flvl != 0), "R10", "fault flag", 32'(res_fault), 32'(flvl != 0));
    check(res_vpn == vpn, poke ? "R9" : "R5", "echoed vpn", 32'(res_vpn), 32'(vpn));
    check(res_ppn == ((flvl == 0) ? p3 : 18'd0), (flvl == 0) ? "R4" : "R6", "result ppn",
          32'(res_ppn), 32'((flvl == 0) ? p3 : 18'd0));
    check(nreads == exp_reads, (flvl == 0) ? "R8" : "R6", "read count", 32'(nreads), 32'(exp_reads));
    check(rd_log[0] == ea[0], "R2", "level-1 address", rd_log[0], ea[0]);
    if (exp_reads > 1) check(rd_log[1] == ea[1], "R3", "level-2 address", rd_log[1], ea[1]);
    if (exp_reads > 2) check(rd_log[2] == ea[2], "R3", "level-3 address", rd_log[2], ea[2]);
    @(negedge clk);
    check(!res_done && !res_fault, "R10", "single-cycle pulse", 32'({res_done, res_fault}), 32'd0);
    check(walk_ready, "R9", "ready after walk", 32'(walk_ready), 32'd1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] root;
    rst = 1; base_wr_en = 0; base_wr_kernel = 0; base_wr_data = '0;
    walk_req = 0; walk_vpn = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check(walk_ready == 1, "R1", "ready after reset", 32'(walk_ready), 32'd1);
    check(mem_req == 0, "R1", "no request after reset", 32'(mem_req), 32'd0);
    check(!res_done && !res_fault, "R1", "no result after reset", 32'({res_done, res_fault}), 32'd0);
    // R1: root is zero, so level-1 address is only the index offset
    run_walk(20'hABCDE, 32'd0, 0, 0, 0, 0);

    // R7: kernel write applies, user write is ignored
    write_base(32'h0004_0000, 1'b1);
    write_base(32'h1234_5000, 1'b0);
    run_walk(20'h5A3C1, 32'h0004_0000, 0, 1, 1, 0);
    root = 32'h0004_0000;

    // Sweep fault level, latencies and page numbers (R2..R6, R8, R9)
    for (int fl = 0; fl < 4; fl++)
      for (int lat = 0; lat < 3; lat++)
        for (int i = 0; i < 6; i++)
          run_walk({7'(i * 37 + fl), 7'(i * 19 + lat), 6'(i * 11 + 5)}, root,
                   fl, lat, 2 - lat, i == 2);

    // Corners: root near top of address space (carry wraps), all-ones / zero VPN
    write_base(32'hFFFF_FF00, 1'b1);
    root = 32'hFFFF_FF00;
    for (int fl = 0; fl < 4; fl++) begin
      run_walk(20'hFFFFF, root, fl, 0, 0, 0);
      run_walk(20'h00000, root, fl, 2, 0, 1);
    end
    write_base(32'h0000_1000, 1'b0);   // R7 ignored again
    run_walk(20'h80001, root, 0, 0, 1, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule